// File: doc/BRIEF.md
# Receive Buffer Space Allocator

This block keeps track of where received frames go inside the receive buffer pool of a DMA-based Ethernet-style controller. Buffer resources are described by entries in a circular table in memory. The block holds the read pointer into that table and the address and word count of the buffer that is currently open. The entries themselves arrive from the memory side, which sits outside the block. For every incoming frame it works out how many bytes the frame takes in memory: the frame, four CRC bytes, and padding with the fill byte 0xFF up to the bus word boundary. It then either grants a write address and advances the buffer state, or reports that the frame does not fit.

When a frame does not fit, the block marks the buffer as finished. It then asks for the next table entry, unless the table is used up. In that case it stalls, and later frames are dropped silently until software supplies a new resource. A separate interrupt warns software when the read pointer catches up with the write pointer. A per-frame sequence counter counts stored frames.

Top module: `rx_buf_alloc`

## Requirements
- R1: For a frame of N bytes, `store_len` is N+4 rounded up to a multiple of 2 when `wide_mode`=0, or to a multiple of 4 when `wide_mode`=1. `pad_len` is the number of fill bytes added, and `pad_data` is always 0xFF.
- R2: When a frame fits, `store_valid` pulses one cycle after `frm_valid`. At that point `store_addr` holds the previous `buf_addr`, `buf_addr` has grown by `store_len`, and `words_left` has dropped by `store_len`/2.
- R3: When `store_len` exceeds twice `words_left`, the frame is not stored. `irq_rbae` pulses, `last_pkt` is set, and `buf_addr`, `words_left`, `store_*` and `seq_cnt` stay unchanged.
- R4: A resource delivery (`res_valid`) loads `buf_addr` and `words_left`. It moves `rd_ptr` forward by 8 bytes in 16-bit mode or 16 bytes in 32-bit mode. If the result equals the end pointer, `rd_ptr` becomes the start pointer instead.
- R5: `irq_rbe` pulses one cycle after a delivery whose new `rd_ptr` equals the table write pointer.
- R6: After an accepted frame attempt, if `last_pkt` is set, the block checks the read pointer. If `rd_ptr` equals the write pointer, `stall` is set. Otherwise `fetch_req` pulses once.
- R7: While `stall` is 1, each frame produces a `frm_dropped` pulse and changes no other state. A resource delivery clears both `stall` and `last_pkt`.
- R8: Each stored frame increments the low byte of `seq_cnt` modulo 256. The high byte keeps its reset value 0x00.
- R9: The start, end and write pointer inputs and the `rp_load_val` value are aligned before use. Bit 0 is cleared in 16-bit mode, and bits 1:0 are cleared in 32-bit mode.
- R10: `cmd_fetch` makes `fetch_req` pulse in the next cycle.
- R11: Priority is `rp_load` over `res_valid` over `frm_valid`. A lower-priority request in the same cycle is ignored.
- R12: After reset, every pointer, address, count, flag and pulse output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_mode | input | 1 | 1 = 32-bit bus mode, 0 = 16-bit |
| res_start | input | 16 | Resource table start pointer |
| res_end | input | 16 | Resource table end pointer |
| res_wr_ptr | input | 16 | Resource table write pointer (software side) |
| rp_load | input | 1 | Load the read pointer |
| rp_load_val | input | 16 | Value for the read pointer load |
| cmd_fetch | input | 1 | Software command to read the next resource |
| res_valid | input | 1 | A resource entry is delivered this cycle |
| res_buf_addr | input | 32 | Buffer address of the delivered entry |
| res_word_cnt | input | 32 | Buffer size of the delivered entry, in 16-bit words |
| frm_valid | input | 1 | A frame is presented for storage |
| frm_len | input | 16 | Frame length in bytes, without CRC |
| fetch_req | output | 1 | Pulse: read the next resource entry |
| rd_ptr | output | 16 | Resource table read pointer |
| buf_addr | output | 32 | Next free byte address in the current buffer |
| words_left | output | 32 | Remaining 16-bit words in the current buffer |
| store_valid | output | 1 | Pulse: a frame was granted space |
| store_addr | output | 32 | Write address of the granted frame |
| store_len | output | 17 | Padded stored length of the granted frame |
| pad_len | output | 2 | Fill bytes appended after the CRC |
| pad_data | output | 8 | Fill byte value |
| seq_cnt | output | 16 | Receive sequence counter |
| last_pkt | output | 1 | Current buffer is finished |
| stall | output | 1 | Reception stalled, frames are dropped |
| frm_dropped | output | 1 | Pulse: a frame was dropped while stalled |
| irq_rbae | output | 1 | Pulse: frame exceeded the buffer space |
| irq_rbe | output | 1 | Pulse: resource table exhausted |

## Verification
The bench feeds frame lengths of every residue modulo 4 in both bus modes. A wrong rounding mask would misplace the next write address and drain the word count at the wrong rate. It shrinks a buffer until a frame misses by a couple of words. A fit test that compares words against bytes, or an off-by-one, would store a frame that overruns the buffer or reject one that fits. It walks the read pointer onto the end pointer and onto the write pointer, so a missing wrap or a missing exhaustion check shows up as a wrong pointer, a lost `fetch_req` or a missing stall. It also checks that a stalled block leaves all state untouched, that the sequence counter wraps in its low byte only, and that simultaneous requests resolve in the stated priority.

// File: rtl/rxba_pkg.sv
package rxba_pkg;
   localparam int CRC_BYTES    = 4;
   localparam int ENTRY_WORDS  = 4;
   localparam int NARROW_BYTES = 2;
   localparam int WIDE_BYTES   = 4;

   function automatic logic [15:0] align_mask(input logic wide);
      return wide ? 16'hFFFC : 16'hFFFE;
   endfunction
endpackage

// File: rtl/rxba_pad.sv
module rxba_pad #(
   parameter int LEN_W   = 16,
   parameter bit WIDE_EN = 1'b1
) (
   input  logic             wide,
   input  logic [LEN_W-1:0] frm_len,
   output logic [LEN_W:0]   raw_len,
   output logic [LEN_W:0]   padded_len,
   output logic [1:0]       pad_bytes
);
   import rxba_pkg::*;
   localparam int PL_W = LEN_W + 1;

   logic [PL_W-1:0] minus1;

   if (LEN_W < 8) begin : g_len_chk
      $error("rxba_pad: LEN_W too small");
   end

   always_comb begin
      raw_len = {1'b0, frm_len} + PL_W'(CRC_BYTES);
      minus1  = raw_len - PL_W'(1);
   end

   if (WIDE_EN) begin : g_both
      always_comb begin
         if (wide) padded_len = (minus1 | PL_W'(3)) + PL_W'(1);
         else      padded_len = (minus1 | PL_W'(1)) + PL_W'(1);
      end
   end else begin : g_narrow
      logic unused_wide;
      assign unused_wide = wide;
      always_comb padded_len = (minus1 | PL_W'(1)) + PL_W'(1);
   end

   always_comb begin
      logic [PL_W-1:0] diff;
      diff      = padded_len - raw_len;
      pad_bytes = diff[1:0];
   end
endmodule

// File: rtl/rxba_ring.sv
module rxba_ring #(
   parameter int PTR_W   = 16,
   parameter bit WIDE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wide,
   input  logic [PTR_W-1:0] start_m,
   input  logic [PTR_W-1:0] end_m,
   input  logic [PTR_W-1:0] wp_m,
   input  logic             do_load,
   input  logic [PTR_W-1:0] load_m,
   input  logic             do_fetch,
   output logic [PTR_W-1:0] rd_ptr,
   output logic             rd_at_wp,
   output logic             rbe_pulse
);
   import rxba_pkg::*;
   localparam int STEP_N = ENTRY_WORDS * NARROW_BYTES;
   localparam int STEP_W = ENTRY_WORDS * WIDE_BYTES;

   logic [PTR_W-1:0] step, inc, nxt;

   if (PTR_W < 8 || PTR_W > 16) begin : g_ptr_chk
      $error("rxba_ring: PTR_W must be 8..16");
   end

   if (WIDE_EN) begin : g_step_both
      assign step = wide ? PTR_W'(STEP_W) : PTR_W'(STEP_N);
   end else begin : g_step_narrow
      assign step = PTR_W'(STEP_N);
   end

   always_comb begin
      inc = rd_ptr + step;
      nxt = (inc == end_m) ? start_m : inc;
   end

   assign rd_at_wp = (rd_ptr == wp_m);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr    <= '0;
         rbe_pulse <= 1'b0;
      end else begin
         rbe_pulse <= 1'b0;
         if (do_load) begin
            rd_ptr <= load_m;
         end else if (do_fetch) begin
            rd_ptr    <= nxt;
            rbe_pulse <= (nxt == wp_m);
         end
      end
   end

   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (do_fetch && !do_load && start_m != end_m) |=> (rd_ptr != $past(end_m)));

   p_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ptr[0] == 1'b0);
endmodule

// File: rtl/rxba_space.sv
module rxba_space #(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              do_fetch,
   input  logic [ADDR_W-1:0] new_addr,
   input  logic [CNT_W-1:0]  new_cnt,
   input  logic              do_store,
   input  logic [LEN_W:0]    padded_len,
   input  logic [1:0]        pad_bytes,
   output logic              fits,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [CNT_W-1:0]  words_left,
   output logic [ADDR_W-1:0] store_addr,
   output logic [LEN_W:0]    store_len,
   output logic [1:0]        pad_len
);
   if (LEN_W >= CNT_W) begin : g_cnt_chk
      $error("rxba_space: CNT_W must exceed LEN_W");
   end
   if (LEN_W >= ADDR_W) begin : g_addr_chk
      $error("rxba_space: ADDR_W must exceed LEN_W");
   end

   always_comb fits = ((CNT_W+1)'(padded_len) <= {words_left, 1'b0});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_addr   <= '0;
         words_left <= '0;
         store_addr <= '0;
         store_len  <= '0;
         pad_len    <= '0;
      end else if (do_fetch) begin
         buf_addr   <= new_addr;
         words_left <= new_cnt;
      end else if (do_store) begin
         store_addr <= buf_addr;
         store_len  <= padded_len;
         pad_len    <= pad_bytes;
         buf_addr   <= buf_addr + ADDR_W'(padded_len);
         words_left <= words_left - CNT_W'(padded_len >> 1);
      end
   end

   p_words_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (do_store && !do_fetch) |=> (words_left + CNT_W'(store_len >> 1) == $past(words_left)));

   p_nofit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!do_store && !do_fetch) |=> ($stable(buf_addr) && $stable(words_left)));
endmodule

// File: rtl/rx_buf_alloc.sv
module rx_buf_alloc #(
   parameter int       PTR_W       = 16,
   parameter int       ADDR_W      = 32,
   parameter int       CNT_W       = 32,
   parameter int       LEN_W       = 16,
   parameter int       SEQ_W       = 16,
   parameter bit       WIDE_EN     = 1'b1,
   parameter bit [7:0] PAD_BYTE    = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide_mode,
   input  logic [PTR_W-1:0]  res_start,
   input  logic [PTR_W-1:0]  res_end,
   input  logic [PTR_W-1:0]  res_wr_ptr,
   input  logic              rp_load,
   input  logic [PTR_W-1:0]  rp_load_val,
   input  logic              cmd_fetch,
   input  logic              res_valid,
   input  logic [ADDR_W-1:0] res_buf_addr,
   input  logic [CNT_W-1:0]  res_word_cnt,
   input  logic              frm_valid,
   input  logic [LEN_W-1:0]  frm_len,
   output logic              fetch_req,
   output logic [PTR_W-1:0]  rd_ptr,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [CNT_W-1:0]  words_left,
   output logic              store_valid,
   output logic [ADDR_W-1:0] store_addr,
   output logic [LEN_W:0]    store_len,
   output logic [1:0]        pad_len,
   output logic [7:0]        pad_data,
   output logic [SEQ_W-1:0]  seq_cnt,
   output logic              last_pkt,
   output logic              stall,
   output logic              frm_dropped,
   output logic              irq_rbae,
   output logic              irq_rbe
);
   import rxba_pkg::*;
   localparam int SEQ_LO = SEQ_W / 2;

   if (SEQ_W < 4 || (SEQ_W % 2) != 0) begin : g_seq_chk
      $error("rx_buf_alloc: SEQ_W must be even and at least 4");
   end

   logic             wide;
   logic [PTR_W-1:0] mask, start_m, end_m, wp_m, load_m;
   logic             do_load, do_fetch, do_frm;
   logic             frm_drop, frm_try, frm_store, frm_over, last_nx;
   logic             rd_at_wp, fits;
   logic [LEN_W:0]   raw_len, padded_len;
   logic [1:0]       pad_bytes;

   if (WIDE_EN) begin : g_mode_both
      assign wide = wide_mode;
   end else begin : g_mode_narrow
      logic unused_mode;
      assign unused_mode = wide_mode;
      assign wide = 1'b0;
   end

   always_comb begin
      mask    = PTR_W'(align_mask(wide));
      start_m = res_start & mask;
      end_m   = res_end & mask;
      wp_m    = res_wr_ptr & mask;
      load_m  = rp_load_val & mask;
   end

   always_comb begin
      do_load   = rp_load;
      do_fetch  = res_valid & ~rp_load;
      do_frm    = frm_valid & ~rp_load & ~res_valid;
      frm_drop  = do_frm & stall;
      frm_try   = do_frm & ~stall;
      frm_store = frm_try & fits;
      frm_over  = frm_try & ~fits;
      last_nx   = last_pkt | frm_over;
   end

   rxba_pad #(.LEN_W(LEN_W), .WIDE_EN(WIDE_EN)) u_pad (
      .wide       (wide),
      .frm_len    (frm_len),
      .raw_len    (raw_len),
      .padded_len (padded_len),
      .pad_bytes  (pad_bytes)
   );

   rxba_ring #(.PTR_W(PTR_W), .WIDE_EN(WIDE_EN)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .wide      (wide),
      .start_m   (start_m),
      .end_m     (end_m),
      .wp_m      (wp_m),
      .do_load   (do_load),
      .load_m    (load_m),
      .do_fetch  (do_fetch),
      .rd_ptr    (rd_ptr),
      .rd_at_wp  (rd_at_wp),
      .rbe_pulse (irq_rbe)
   );

   rxba_space #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_space (
      .clk        (clk),
      .rst_n      (rst_n),
      .do_fetch   (do_fetch),
      .new_addr   (res_buf_addr),
      .new_cnt    (res_word_cnt),
      .do_store   (frm_store),
      .padded_len (padded_len),
      .pad_bytes  (pad_bytes),
      .fits       (fits),
      .buf_addr   (buf_addr),
      .words_left (words_left),
      .store_addr (store_addr),
      .store_len  (store_len),
      .pad_len    (pad_len)
   );

   assign pad_data = PAD_BYTE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stall       <= 1'b0;
         last_pkt    <= 1'b0;
         seq_cnt     <= '0;
         fetch_req   <= 1'b0;
         store_valid <= 1'b0;
         frm_dropped <= 1'b0;
         irq_rbae    <= 1'b0;
      end else begin
         store_valid <= frm_store;
         frm_dropped <= frm_drop;
         irq_rbae    <= frm_over;
         fetch_req   <= cmd_fetch | (frm_try & last_nx & ~rd_at_wp);
         if (do_fetch) begin
            stall    <= 1'b0;
            last_pkt <= 1'b0;
         end else begin
            if (frm_over) last_pkt <= 1'b1;
            if (frm_try & last_nx & rd_at_wp) stall <= 1'b1;
         end
         if (frm_store)
            seq_cnt[SEQ_LO-1:0] <= seq_cnt[SEQ_LO-1:0] + SEQ_LO'(1);
      end
   end

   p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && stall && !rp_load && !res_valid) |=> (frm_dropped && !store_valid && $stable(seq_cnt)));

   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !rp_load) |=> (!stall && !last_pkt));

   p_seq_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(seq_cnt[SEQ_W-1:SEQ_LO]));

   p_len_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
      store_valid |-> (store_len[0] == 1'b0));

   p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(store_valid && irq_rbae));
endmodule

// File: tb/rx_buf_alloc_bench.sv
module rx_buf_alloc_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        wide_mode = 1'b0;
   logic [15:0] res_start = '0, res_end = '0, res_wr_ptr = '0, rp_load_val = '0;
   logic        rp_load = 1'b0, cmd_fetch = 1'b0, res_valid = 1'b0, frm_valid = 1'b0;
   logic [31:0] res_buf_addr = '0, res_word_cnt = '0;
   logic [15:0] frm_len = '0;

   logic        fetch_req, store_valid, last_pkt, stall, frm_dropped, irq_rbae, irq_rbe;
   logic [15:0] rd_ptr, seq_cnt;
   logic [31:0] buf_addr, words_left, store_addr;
   logic [16:0] store_len;
   logic [1:0]  pad_len;
   logic [7:0]  pad_data;

   rx_buf_alloc u_rx_buf_alloc (
      .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
      .res_start(res_start), .res_end(res_end), .res_wr_ptr(res_wr_ptr),
      .rp_load(rp_load), .rp_load_val(rp_load_val), .cmd_fetch(cmd_fetch),
      .res_valid(res_valid), .res_buf_addr(res_buf_addr), .res_word_cnt(res_word_cnt),
      .frm_valid(frm_valid), .frm_len(frm_len),
      .fetch_req(fetch_req), .rd_ptr(rd_ptr), .buf_addr(buf_addr), .words_left(words_left),
      .store_valid(store_valid), .store_addr(store_addr), .store_len(store_len),
      .pad_len(pad_len), .pad_data(pad_data), .seq_cnt(seq_cnt), .last_pkt(last_pkt),
      .stall(stall), .frm_dropped(frm_dropped), .irq_rbae(irq_rbae), .irq_rbe(irq_rbe)
   );

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // reference state
   int m_rd = 0, m_buf = 0, m_words = 0, m_saddr = 0, m_slen = 0, m_pad = 0, m_seq = 0;
   bit m_last = 0, m_stall = 0, m_freq = 0, m_sv = 0, m_drop = 0, m_rbae = 0, m_rbe = 0;

   task automatic chk(input string req, input string nm, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, nm, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R4", "rd_ptr", rd_ptr, m_rd & 16'hFFFF);
      chk("R2", "buf_addr", buf_addr, m_buf & 32'hFFFFFFFF);
      chk("R2", "words_left", words_left, m_words & 32'hFFFFFFFF);
      chk("R2", "store_valid", store_valid, m_sv);
      chk("R2", "store_addr", store_addr, m_saddr & 32'hFFFFFFFF);
      chk("R1", "store_len", store_len, m_slen);
      chk("R1", "pad_len", pad_len, m_pad);
      chk("R1", "pad_data", pad_data, 8'hFF);
      chk("R8", "seq_cnt", seq_cnt, m_seq);
      chk("R3", "last_pkt", last_pkt, m_last);
      chk("R6", "stall", stall, m_stall);
      chk("R6", "fetch_req", fetch_req, m_freq);
      chk("R7", "frm_dropped", frm_dropped, m_drop);
      chk("R3", "irq_rbae", irq_rbae, m_rbae);
      chk("R5", "irq_rbe", irq_rbe, m_rbe);
   endtask

   // advance the model by one clock with the inputs currently driven
   task automatic model_step();
      int msk, s, e, w, raw, padded, nx;
      msk = wide_mode ? 32'hFFFC : 32'hFFFE;
      s = res_start & msk; e = res_end & msk; w = res_wr_ptr & msk;
      m_freq = cmd_fetch; m_sv = 0; m_drop = 0; m_rbae = 0; m_rbe = 0;
      if (rp_load) begin
         m_rd = rp_load_val & msk;                       // R11: highest priority
      end else if (res_valid) begin
         nx = (m_rd + (wide_mode ? 16 : 8)) & 16'hFFFF;
         if (nx == e) nx = s;
         m_rd = nx; m_rbe = (nx == w);
         m_buf = res_buf_addr; m_words = res_word_cnt;
         m_stall = 0; m_last = 0;
      end else if (frm_valid) begin
         if (m_stall) m_drop = 1;
         else begin
            raw = frm_len + 4;
            padded = raw;
            while (padded % (wide_mode ? 4 : 2) != 0) padded++;
            if (longint'(padded) > 2 * longint'(unsigned'(m_words))) begin
               m_rbae = 1; m_last = 1;
            end else begin
               m_sv = 1; m_saddr = m_buf; m_slen = padded; m_pad = padded - raw;
               m_buf = m_buf + padded; m_words = m_words - padded / 2;
               m_seq = (m_seq & 16'hFF00) | ((m_seq + 1) & 16'h00FF);
            end
            if (m_last) begin
               if (m_rd == w) m_stall = 1; else m_freq = 1;
            end
         end
      end
   endtask

   task automatic cyc();
      model_step();
      @(posedge clk);
      #2;
      compare_all();
      @(negedge clk);
      rp_load = 0; cmd_fetch = 0; res_valid = 0; frm_valid = 0;
   endtask

   task automatic fetch(input int addr, input int cnt);
      res_valid = 1; res_buf_addr = addr; res_word_cnt = cnt; cyc();
   endtask

   task automatic frame(input int len);
      frm_valid = 1; frm_len = len[15:0]; cyc();
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      compare_all();                                       // R12 reset values
      rst_n = 1;
      @(negedge clk);
      cyc();                                               // R12 idle after reset

      // R9 alignment of loaded pointer, 16-bit mode
      res_start = 16'h0101; res_end = 16'h0141; res_wr_ptr = 16'h0131;
      rp_load = 1; rp_load_val = 16'h0121; cyc();
      // R4 fetch, no exhaustion
      fetch(32'h1000, 100);
      // R1/R2 residues in 16-bit mode: 60,61,62 fit
      frame(60); frame(61); frame(62);
      // R3 only 2 words left: 63+4 -> 68 bytes does not fit; R6 fetch_req
      frame(63);
      // R5 next fetch lands on write pointer
      fetch(32'h2000, 40);
      // R10 software command
      cmd_fetch = 1; cyc();
      // R3/R6 overflow with rd at wp -> stall
      frame(90);
      // R7 drops while stalled
      frame(10); frame(20);
      // R11 frame with res_valid: frame ignored; R7 fetch clears stall
      wide_mode = 1;
      res_valid = 1; res_buf_addr = 32'h3000; res_word_cnt = 200; frm_valid = 1; frm_len = 50; cyc();
      // R1/R2 32-bit residues
      frame(60); frame(61); frame(62); frame(63);
      // R4 wrap in 32-bit mode: load 0x130, +16 = 0x140 = end -> start
      rp_load = 1; rp_load_val = 16'h0133; res_valid = 1; cyc();   // R11 load beats fetch
      fetch(32'h4002, 8);
      // R3 exact fit boundary: 8 words = 16 bytes; len 12 -> 16 fits, then 0 words
      frame(12);
      frame(0);
      // R9 write pointer alignment in 32-bit mode changes equality
      res_wr_ptr = 16'h0112;
      fetch(32'h5000, 3);
      frame(8);
      frame(8);
      // R8 low byte wrap after 256+ stored frames
      wide_mode = 0;
      fetch(32'h8000, 100000);
      for (int i = 0; i < 262; i++) frame(60 + (i % 3));
      // R7 frame after fetch with no stall is stored
      frame(1);
      cyc();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule